// File: doc/BRIEF.md
# Four-Phase Handshake Word Read Requester

This block is the device side of a read over a shared, unclocked bus. Address and data use the same 32 lines, and a single read takes two four-phase exchanges. First the requester drives the address and raises its request line, which the memory answers with an acknowledge. Then the memory drives the word and raises its data-ready line, which the requester answers with its own acknowledge. The block therefore acts as initiator in the first exchange and as responder in the second.

A local client issues a read by pulsing `start` with an address. The block runs both exchanges. Every decision it takes on the bus lines uses copies that have passed through a multi-flop synchronizer. At the end it places the word on `rdata` and pulses `done` for one cycle. All bus outputs come straight from flip-flops, so they never glitch. The block drives the shared lines only while its request is raised.

Top module: `hs_read_requester`

## Requirements
- R1: During and after a synchronous reset, `read_req`, `bus_ack`, `done` and `busy` are low, `rdata` is zero and the shared lines are not driven.
- R2: A `start` accepted while idle drives `start_addr` onto `bus_ad` and then raises `read_req`, and `busy` stays high until the transfer completes.
- R3: Once the synchronized `bus_mem_ack` is seen high, `read_req` falls and the block stops driving `bus_ad` on that same clock edge.
- R4: After the memory acknowledge is seen low again, the block waits for the synchronized `data_rdy` to be high. It then captures `bus_ad` and raises `bus_ack`. The captured word equals what the memory drove.
- R5: `bus_ack` stays high for as long as `data_rdy` is held high, and it falls only after `data_rdy` has been observed low.
- R6: `done` is high for exactly one cycle, on the edge where `bus_ack` falls. At that edge `rdata` takes the captured word and then holds it until the next transfer completes.
- R7: `read_req` is never raised while the synchronized `bus_mem_ack` or `data_rdy` is high. A pending read waits, with `busy` high, until both are low.
- R8: A `start` pulse that arrives while `busy` is high is ignored. It starts no second transfer and does not change the address of the transfer in progress.
- R9: `bus_mem_ack` and `data_rdy` each pass through SYNC_STAGES flip-flops (default 2). With bench inputs changing between clock edges, the block reacts on the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Read command pulse |
| start_addr | input | 32 | Word address for the read |
| rdata | output | 32 | Word returned by the last completed read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A read is pending or in progress |
| read_req | output | 1 | Bus request for the address phase |
| data_rdy | input | 1 | Memory signals that data is valid (asynchronous) |
| bus_ack | output | 1 | Requester acknowledge for the data phase |
| bus_mem_ack | input | 1 | Memory acknowledge for the address phase (asynchronous) |
| bus_ad | inout | 32 | Shared address/data lines, tri-state |

## Verification
The read path is tested with several address patterns: all zeros, all ones, a single high and low bit, and ordinary values. Each memory word is derived from its address, so the bench can tell a mixed-up phase from a correct capture. The memory model's reply delay, data latency and data-ready hold time vary from read to read. Exact cycle counts from the memory's acknowledge to the fall of `read_req` show the synchronizer depth. A long hold keeps `bus_ack` high and confirms it stays there. Two further runs check quiet-bus gating and the ignoring of starts while busy: one leaves an input stuck high before a start, and the other pulses a second start mid-transfer.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_REQ   = 3'd2,
    ST_ALOW  = 3'd3,
    ST_DWAIT = 3'd4,
    ST_DACK  = 3'd5
  } hsr_state_e;
endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/hsr_seq.sv
module hsr_seq
  import hsr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mack_s,
  input  logic drdy_s,
  output logic req_q,
  output logic ack_q,
  output logic oe_q,
  output logic done_q,
  output logic busy_q,
  output logic load,
  output logic capture,
  output logic commit
);
  hsr_state_e state, state_n;
  logic quiet;

  assign quiet = !mack_s && !drdy_s;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  if (start)   state_n = ST_ARM;
      ST_ARM:   if (quiet)   state_n = ST_REQ;
      ST_REQ:   if (mack_s)  state_n = ST_ALOW;
      ST_ALOW:  if (!mack_s) state_n = ST_DWAIT;
      ST_DWAIT: if (drdy_s)  state_n = ST_DACK;
      ST_DACK:  if (!drdy_s) state_n = ST_IDLE;
      default:               state_n = ST_IDLE;
    endcase
  end

  assign load    = (state == ST_IDLE)  && start;
  assign capture = (state == ST_DWAIT) && drdy_s;
  assign commit  = (state == ST_DACK)  && !drdy_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      state  <= state_n;
      req_q  <= (state_n == ST_REQ);
      oe_q   <= (state_n == ST_REQ);
      ack_q  <= (state_n == ST_DACK);
      done_q <= commit;
      busy_q <= (state_n != ST_IDLE);
    end
  end
endmodule

// File: rtl/hsr_datapath.sv
module hsr_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] start_addr,
  input  logic         capture,
  input  logic         commit,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] addr_q,
  output logic [W-1:0] rdata_q
);
  logic [W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      cap_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (load)    addr_q  <= start_addr;
      if (capture) cap_q   <= bus_in;
      if (commit)  rdata_q <= cap_q;
    end
  end
endmodule

// File: rtl/hs_read_requester.sv
module hs_read_requester #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] start_addr,
  output logic [W-1:0] rdata,
  output logic         done,
  output logic         busy,
  output logic         read_req,
  input  logic         data_rdy,
  output logic         bus_ack,
  input  logic         bus_mem_ack,
  inout  wire  [W-1:0] bus_ad
);
  logic         mack_s;
  logic         drdy_s;
  logic         drv_en;
  logic         load;
  logic         capture;
  logic         commit;
  logic [W-1:0] addr_q;
  logic [W-1:0] bus_in;

  hsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mack (
    .clk(clk), .rst(rst), .d(bus_mem_ack), .q(mack_s)
  );

  hsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_drdy (
    .clk(clk), .rst(rst), .d(data_rdy), .q(drdy_s)
  );

  hsr_seq u_seq (
    .clk(clk), .rst(rst), .start(start),
    .mack_s(mack_s), .drdy_s(drdy_s),
    .req_q(read_req), .ack_q(bus_ack), .oe_q(drv_en),
    .done_q(done), .busy_q(busy),
    .load(load), .capture(capture), .commit(commit)
  );

  hsr_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
    .capture(capture), .commit(commit), .bus_in(bus_in),
    .addr_q(addr_q), .rdata_q(rdata)
  );

  assign bus_ad = drv_en ? addr_q : {W{1'bz}};
  assign bus_in = bus_ad;
endmodule

// File: rtl/hsr_chk.sv
module hsr_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         read_req,
  input logic         bus_ack,
  input logic         drv_en,
  input logic         data_rdy,
  input logic         bus_mem_ack,
  input logic [W-1:0] addr_q,
  input logic [W-1:0] rdata
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!read_req && !bus_ack && !done && !busy && !drv_en));

  // R3
  release_lines_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(read_req) |-> !drv_en);

  // R2
  drive_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    read_req |-> (drv_en && busy));

  // R9
  req_drop_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(read_req) |-> $past(bus_mem_ack, 2));

  // R5
  ack_drop_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack) |-> !$past(data_rdy, 2));

  // R7
  quiet_launch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(read_req) |-> (!$past(bus_mem_ack, 2) && !$past(data_rdy, 2)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(bus_ack));

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));

  // R8
  ignore_busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(addr_q));

  // R4
  roles_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(read_req && bus_ack));
endmodule

bind hs_read_requester hsr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .read_req(read_req), .bus_ack(bus_ack), .drv_en(drv_en),
  .data_rdy(data_rdy), .bus_mem_ack(bus_mem_ack),
  .addr_q(addr_q), .rdata(rdata)
);

// File: tb/tb_hs_read_requester.sv
module tb_hs_read_requester;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] start_addr = '0;
  logic [W-1:0] rdata;
  logic         done, busy, read_req, bus_ack;
  logic         data_rdy = 1'b0;
  logic         mem_ack = 1'b0;
  logic         mem_oe = 1'b0;
  logic [W-1:0] mem_word = '0;
  wire  [W-1:0] ad_bus;

  assign ad_bus = mem_oe ? mem_word : {W{1'bz}};

  always #10 clk = ~clk;

  hs_read_requester #(.W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .rdata(rdata), .done(done), .busy(busy), .read_req(read_req),
    .data_rdy(data_rdy), .bus_ack(bus_ack), .bus_mem_ack(mem_ack),
    .bus_ad(ad_bus)
  );

  int total = 0;
  int bad = 0;
  int n_txn = 0;
  int resp_dly = 1, data_lat = 2, hold = 0;
  logic [W-1:0] cur_addr = '0;
  logic [W-1:0] last_word = '0;
  bit           have_last = 0;
  logic [W-1:0] exp_q[$];
  logic         prev_done = 1'b0;
  bit           finished = 0;

  function automatic logic [W-1:0] mem_val(input logic [W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: issue one read and record the expected word
  task automatic do_read(input logic [W-1:0] a, input int d, input int l, input int h);
    @(negedge clk);
    while (busy) @(negedge clk);
    resp_dly = d; data_lat = l; hold = h;
    cur_addr = a;
    exp_q.push_back(mem_val(a));
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: compare completions against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected done", rdata, '0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(rdata == e, "R4 captured word", rdata, e);
          chk(!bus_ack, "R6 ack low with done", {31'd0, bus_ack}, '0);
          last_word = e; have_last = 1;
        end
      end
      if (prev_done) chk(!done, "R6 done one cycle", {31'd0, done}, '0);
      prev_done = done;
    end
  end

  // memory-side responder
  initial begin
    forever begin
      @(negedge clk);
      if (read_req && !finished) begin
        int k;
        logic [W-1:0] a;
        a = ad_bus;
        chk(a == cur_addr, "R2 address on lines", a, cur_addr);
        if (have_last) chk(rdata == last_word, "R6 rdata held", rdata, last_word);
        repeat (resp_dly) @(negedge clk);
        mem_ack = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (read_req && k < 50);
        chk(k == 3, "R9 req falls 3 edges after ack", k, 3);
        chk(!read_req, "R3 req dropped", {31'd0, read_req}, '0);
        mem_ack = 1'b0;
        repeat (data_lat) @(negedge clk);
        mem_word = mem_val(a);
        mem_oe = 1'b1;
        data_rdy = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!bus_ack && k < 50);
        chk(bus_ack, "R4 ack raised after data ready", {31'd0, bus_ack}, 1);
        for (int i = 0; i < hold; i++) begin
          @(negedge clk);
          chk(bus_ack && !done, "R5 ack held while data ready high",
              {30'd0, bus_ack, done}, 2);
        end
        data_rdy = 1'b0;
        mem_oe = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (bus_ack && k < 50);
        chk(k == 3, "R5 ack falls 3 edges after data ready low", k, 3);
        n_txn++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    // R1
    chk(!read_req && !bus_ack && !done && !busy, "R1 outputs low in reset",
        {28'd0, read_req, bus_ack, done, busy}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(!read_req && !bus_ack && !done && !busy, "R1 outputs low after reset",
        {28'd0, read_req, bus_ack, done, busy}, '0);
    chk(rdata == '0, "R1 rdata zero", rdata, '0);

    // main function, varied patterns and timing (R2 R3 R4 R5 R6 R9)
    do_read(32'h0000_1000, 1, 2, 0); wait_idle();
    do_read(32'h0000_0000, 0, 0, 0); wait_idle();
    do_read(32'hFFFF_FFFF, 3, 5, 4); wait_idle();
    do_read(32'h8000_0001, 2, 1, 7); wait_idle();
    do_read(32'h1234_5678, 0, 4, 1); wait_idle();

    // R8: start while busy is ignored
    base = n_txn;
    do_read(32'h0BAD_F00D, 4, 3, 2);
    @(negedge clk);
    while (!read_req) @(negedge clk);
    chk(busy, "R8 busy during transfer", {31'd0, busy}, 1);
    start = 1'b1; start_addr = 32'hDEAD_0000;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (read_req) chk(0, "R8 extra request launched", 1, 0);
    end
    chk(n_txn == base + 1, "R8 single transfer", n_txn, base + 1);
    chk(!busy, "R8 idle afterwards", {31'd0, busy}, '0);

    // R7: stuck data ready blocks the launch
    data_rdy = 1'b1;
    repeat (4) @(negedge clk);
    do_read(32'h0000_00A5, 1, 1, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!read_req && busy, "R7 waits for quiet data ready",
          {30'd0, read_req, busy}, 1);
    end
    data_rdy = 1'b0;
    wait_idle();

    // R7: stuck memory acknowledge blocks the launch
    mem_ack = 1'b1;
    repeat (4) @(negedge clk);
    do_read(32'h5A00_005A, 1, 1, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!read_req && busy, "R7 waits for quiet ack",
          {30'd0, read_req, busy}, 1);
    end
    mem_ack = 1'b0;
    wait_idle();

    chk(n_txn == 8, "R2 transfer count", n_txn, 8);
    finished = 1;
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule